// File: doc/BRIEF.md
# DMA Terminal Count Controller

This block closes out a DMA service for a multi-channel DMA controller (four channels by default). Each cycle it looks at the count-expired flag of the channel that is in service. It also watches an active-low end-of-process line that can come from outside. When either source calls for an end, it terminates the service with a one-cycle strobe. On the same edge it records terminal count for the channel. It then either masks that channel or, for a channel set to autoinitialize, asks the channel register file to reload the current address and count from the base values.

The end-of-process line is bidirectional. The block pulls it low for one cycle when the end comes from an internal terminal count, and it never drives the line high. An external pull-up is assumed. In memory-to-memory mode the source channel (channel 0) reaching terminal count is not an end of service. Only the destination channel (channel 1) reaching terminal count ends the transfer. A low driven onto the line from outside passes through a synchronizer before use, and it has no effect while no channel is in service.

The controller has three states:
- `ST_WATCH` waits for an event. `WATCH_TO_END` is taken on an internal or external event while a channel is in service.
- `ST_END` lasts exactly one cycle and carries the strobes. `END_TO_HOLD` is always taken.
- `ST_HOLD` waits for the service to be released. `HOLD_TO_WATCH` is taken once `in_service` is low.

Top module: `dma_tc_ctrl`

## Requirements
- R1: After reset, `mask` is all ones, `tc_status` is all zeros, and `eop_pull`, `service_end` and `reload_strobe` are all low.
- R2: The block samples `cnt_expired[active_ch]` high at a rising edge while `in_service` is high and the state is `ST_WATCH`. In the following cycle, `service_end` and `eop_pull` are both high for exactly one cycle.
- R3: When `mem2mem` is 1 and `active_ch` is 0, a terminal count causes no pulse, no strobe and no status change. When `mem2mem` is 1 and `active_ch` is 1, a terminal count is handled as in R2.
- R4: `eop_in_n` passes through two flops. A low sampled at edge k is acted on at edge k+2, provided `in_service` is high there. `service_end` is then high in the cycle after edge k+2, and `eop_pull` stays low.
- R5: When the ending channel has its `autoinit_en` bit set, `reload_strobe` is high only on that channel's bit, only during the `service_end` cycle, and that channel's `mask` bit is not set.
- R6: On an end event, the active channel's `tc_status` bit is set on the event edge. Its `mask` bit is also set on that edge unless the channel autoinitializes.
- R7: `mask_clr[i]` clears `mask[i]` at the next edge. If an end event sets the same bit on that edge, the set wins.
- R8: `status_rd` clears all `tc_status` bits at the next edge. A bit that an end event sets on that edge stays set.
- R9: A low on the synchronized `eop_in_n` while `in_service` is low causes no strobe and no status change.
- R10: After a termination, no further event is taken until `in_service` has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DMA clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_service | input | 1 | A channel currently holds a DMA service |
| active_ch | input | 2 | Index of the channel in service |
| cnt_expired | input | 4 | Per-channel word-count expired flag |
| mem2mem | input | 1 | Memory-to-memory mode (channel 0 source, channel 1 destination) |
| autoinit_en | input | 4 | Per-channel autoinitialize enable |
| eop_in_n | input | 1 | Sensed level of the end-of-process line, active low |
| status_rd | input | 1 | Status register read strobe |
| mask_clr | input | 4 | Per-channel mask clear request |
| eop_pull | output | 1 | Open-drain enable: 1 pulls the end-of-process line low |
| service_end | output | 1 | One-cycle service-terminate strobe |
| reload_strobe | output | 4 | Per-channel current-from-base reload request |
| tc_status | output | 4 | Terminal-count status bits |
| mask | output | 4 | Channel mask bits |

## Verification
The bench builds the block with its default parameters: four channels and a two-stage synchronizer. With these values both special channels of memory-to-memory mode are present, and two ordinary channels remain to exercise autoinitialize apart from the masking path. The two-flop latency of the external line is short enough that a reference model can check, every cycle, the exact edge at which an external low becomes a termination. The bench also places `status_rd` and `mask_clr` on the same edge as an event to check that set takes priority.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_END   = 2'd1,
        ST_HOLD  = 2'd2
    } tc_state_e;

endpackage

// File: rtl/dma_tc_sync.sv
module dma_tc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dma_tc_detect.sv
module dma_tc_detect #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              in_service,
    input  logic [CH_W-1:0]   active_ch,
    input  logic [NUM_CH-1:0] cnt_expired,
    input  logic              mem2mem,
    input  logic              ext_low,
    output logic              int_evt,
    output logic              ext_evt
);
    logic [NUM_CH-1:0] qual;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_qual
        if (i == 0) begin : g_src
            // source channel of a memory-to-memory transfer never ends it
            assign qual[i] = cnt_expired[i] && (active_ch == CH_W'(i)) && !mem2mem;
        end else begin : g_norm
            assign qual[i] = cnt_expired[i] && (active_ch == CH_W'(i));
        end
    end

    assign int_evt = in_service && (|qual);
    assign ext_evt = in_service && ext_low;
endmodule

// File: rtl/dma_tc_fsm.sv
module dma_tc_fsm
    import dma_tc_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_evt,
    input  logic              ext_evt,
    input  logic              in_service,
    input  logic [CH_W-1:0]   active_ch,
    input  logic [NUM_CH-1:0] autoinit_en,
    output logic              ev_fire,
    output logic [CH_W-1:0]   ev_ch,
    output logic              ev_auto,
    output logic              eop_pull,
    output logic              service_end,
    output logic [NUM_CH-1:0] reload_strobe
);
    tc_state_e         state_q, state_d;
    logic [CH_W-1:0]   held_ch;
    logic              held_int;
    logic              held_auto;

    assign ev_fire = (state_q == ST_WATCH) && (int_evt || ext_evt);
    assign ev_ch   = active_ch;
    assign ev_auto = autoinit_en[active_ch];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: if (int_evt || ext_evt) state_d = ST_END;   // WATCH_TO_END
            ST_END:   state_d = ST_HOLD;                          // END_TO_HOLD
            ST_HOLD:  if (!in_service) state_d = ST_WATCH;        // HOLD_TO_WATCH
            default:  state_d = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_ch   <= '0;
            held_int  <= 1'b0;
            held_auto <= 1'b0;
        end else if (ev_fire) begin
            held_ch   <= ev_ch;
            held_int  <= int_evt;
            held_auto <= ev_auto;
        end
    end

    always_comb begin
        service_end   = 1'b0;
        eop_pull      = 1'b0;
        reload_strobe = '0;
        unique case (state_q)
            ST_WATCH: ;
            ST_END: begin
                service_end = 1'b1;
                eop_pull    = held_int;
                if (held_auto) reload_strobe[held_ch] = 1'b1;
            end
            ST_HOLD: ;
            default: ;
        endcase
    end

    // R2
    end_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        service_end |=> !service_end);

    // R10
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && in_service) |=> !service_end);

    // R2
    fire_then_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fire |=> service_end);
endmodule

// File: rtl/dma_tc_status.sv
module dma_tc_status #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_fire,
    input  logic [CH_W-1:0]   ev_ch,
    input  logic              ev_auto,
    input  logic              status_rd,
    input  logic [NUM_CH-1:0] mask_clr,
    output logic [NUM_CH-1:0] tc_status,
    output logic [NUM_CH-1:0] mask
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = ev_fire && (ev_ch == CH_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tc_status[i] <= 1'b0;
            end else if (hit) begin
                tc_status[i] <= 1'b1;
            end else if (status_rd) begin
                tc_status[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[i] <= 1'b1;
            end else if (hit && !ev_auto) begin
                mask[i] <= 1'b1;
            end else if (mask_clr[i]) begin
                mask[i] <= 1'b0;
            end
        end

        // R7
        mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_clr[i] && !(hit && !ev_auto)) |=> !mask[i]);
    end

    // R6
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fire |=> tc_status[$past(ev_ch)]);

    // R5
    auto_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fire && ev_auto && !mask[ev_ch]) |=> !mask[$past(ev_ch)]);

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !ev_fire) |=> (tc_status == '0));
endmodule

// File: rtl/dma_tc_ctrl.sv
module dma_tc_ctrl #(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_service,
    input  logic [CH_W-1:0]   active_ch,
    input  logic [NUM_CH-1:0] cnt_expired,
    input  logic              mem2mem,
    input  logic [NUM_CH-1:0] autoinit_en,
    input  logic              eop_in_n,
    input  logic              status_rd,
    input  logic [NUM_CH-1:0] mask_clr,
    output logic              eop_pull,
    output logic              service_end,
    output logic [NUM_CH-1:0] reload_strobe,
    output logic [NUM_CH-1:0] tc_status,
    output logic [NUM_CH-1:0] mask
);
    logic           eop_sync_n;
    logic           int_evt;
    logic           ext_evt;
    logic           ev_fire;
    logic [CH_W-1:0] ev_ch;
    logic           ev_auto;

    dma_tc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (eop_in_n),
        .q     (eop_sync_n)
    );

    dma_tc_detect #(.NUM_CH(NUM_CH)) u_detect (
        .in_service  (in_service),
        .active_ch   (active_ch),
        .cnt_expired (cnt_expired),
        .mem2mem     (mem2mem),
        .ext_low     (!eop_sync_n),
        .int_evt     (int_evt),
        .ext_evt     (ext_evt)
    );

    dma_tc_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .int_evt       (int_evt),
        .ext_evt       (ext_evt),
        .in_service    (in_service),
        .active_ch     (active_ch),
        .autoinit_en   (autoinit_en),
        .ev_fire       (ev_fire),
        .ev_ch         (ev_ch),
        .ev_auto       (ev_auto),
        .eop_pull      (eop_pull),
        .service_end   (service_end),
        .reload_strobe (reload_strobe)
    );

    dma_tc_status #(.NUM_CH(NUM_CH)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_fire   (ev_fire),
        .ev_ch     (ev_ch),
        .ev_auto   (ev_auto),
        .status_rd (status_rd),
        .mask_clr  (mask_clr),
        .tc_status (tc_status),
        .mask      (mask)
    );

    // R9
    idle_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_service |-> !ev_fire);

    // R3
    m2m_src_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem2mem && active_ch == '0 && eop_sync_n) |-> !ev_fire);

    // R5
    reload_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|reload_strobe) |-> ($countones(reload_strobe) == 1 && service_end));

    // R2
    pull_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pull |-> service_end);
endmodule

// File: tb/dma_tc_ctrl_tb_top.sv
module dma_tc_ctrl_tb_top;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_service = 1'b0;
    logic [1:0]     active_ch = '0;
    logic [NCH-1:0] cnt_expired = '0;
    logic           mem2mem = 1'b0;
    logic [NCH-1:0] autoinit_en = '0;
    logic           eop_in_n = 1'b1;
    logic           status_rd = 1'b0;
    logic [NCH-1:0] mask_clr = '0;
    logic           eop_pull;
    logic           service_end;
    logic [NCH-1:0] reload_strobe;
    logic [NCH-1:0] tc_status;
    logic [NCH-1:0] mask;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #5 clk = ~clk;

    dma_tc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .in_service(in_service), .active_ch(active_ch),
        .cnt_expired(cnt_expired), .mem2mem(mem2mem), .autoinit_en(autoinit_en),
        .eop_in_n(eop_in_n), .status_rd(status_rd), .mask_clr(mask_clr),
        .eop_pull(eop_pull), .service_end(service_end), .reload_strobe(reload_strobe),
        .tc_status(tc_status), .mask(mask)
    );

    // behavioural reference model
    int       m_phase;
    int       m_ch;
    bit       m_int, m_auto;
    bit [3:0] m_tc, m_mask, setb, mset;
    bit       s1, s2, it, ext;
    int       pulses_seen = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_ch = 0; m_int = 0; m_auto = 0;
            m_tc = 4'h0; m_mask = 4'hF; s1 = 1; s2 = 1;
        end else begin
            it  = in_service && cnt_expired[active_ch] && !(mem2mem && active_ch == 0);
            ext = in_service && !s2;
            setb = 4'h0; mset = 4'h0;
            if (m_phase == 0) begin
                if (it || ext) begin
                    m_phase = 1; m_ch = active_ch; m_int = it;
                    m_auto = autoinit_en[active_ch];
                    setb = 4'h1 << active_ch;
                    if (!m_auto) mset = setb;
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else if (!in_service) begin
                m_phase = 0;
            end
            m_tc   = (status_rd ? 4'h0 : m_tc) | setb;
            m_mask = (m_mask & ~mask_clr) | mset;
            s2 = s1; s1 = eop_in_n;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R4", "service_end", service_end, m_phase == 1);
            chk("R2/R3/R4", "eop_pull", eop_pull, m_phase == 1 && m_int);
            chk("R5", "reload_strobe", reload_strobe,
                (m_phase == 1 && m_auto) ? (1 << m_ch) : 0);
            chk("R6/R8", "tc_status", tc_status, m_tc);
            chk("R6/R7", "mask", mask, m_mask);
            if (eop_pull) pulses_seen++;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tc_pulse(input int ch);
        active_ch = 2'(ch); in_service = 1'b1;
        cyc(1);
        cnt_expired[ch] = 1'b1;
        cyc(1);
        cnt_expired = '0;
        cyc(2);
        in_service = 1'b0;
        cyc(2);
    endtask

    initial begin
        cyc(2);
        // R1: reset state
        chk("R1", "mask at reset", mask, 4'hF);
        chk("R1", "tc at reset", tc_status, 0);
        chk("R1", "strobes at reset", {eop_pull, service_end, reload_strobe}, 0);
        rst_n = 1'b1;
        cyc(2);

        // R2 R6: plain terminal count on channel 2
        tc_pulse(2);
        chk("R2", "one eop pulse", pulses_seen, 1);
        // R8: read clears
        status_rd = 1'b1; cyc(1); status_rd = 1'b0; cyc(1);
        chk("R8", "tc cleared", tc_status, 0);

        // R3: memory-to-memory, source channel silent, destination ends
        mem2mem = 1'b1;
        tc_pulse(0);
        chk("R3", "no pulse on ch0", pulses_seen, 1);
        tc_pulse(1);
        chk("R3", "pulse on ch1", pulses_seen, 2);
        mem2mem = 1'b0;

        // R5: autoinit on channel 3 keeps mask clear
        mask_clr = 4'hF; cyc(1); mask_clr = '0;
        autoinit_en = 4'b1000;
        tc_pulse(3);
        chk("R5", "mask3 clear", mask[3], 0);

        // R4: external end on channel 1
        active_ch = 2'd1; in_service = 1'b1; mask_clr = 4'b0010; cyc(1); mask_clr = '0;
        eop_in_n = 1'b0; cyc(1); eop_in_n = 1'b1;
        cyc(4); in_service = 1'b0; cyc(2);
        chk("R4", "no pull for external", pulses_seen, 3);
        chk("R4", "tc1 set", tc_status[1], 1);

        // R9: external low while idle is ignored
        status_rd = 1'b1; cyc(1); status_rd = 1'b0;
        eop_in_n = 1'b0; cyc(4); eop_in_n = 1'b1; cyc(3);
        chk("R9", "tc untouched", tc_status, 0);

        // R10: second expiry while held is ignored
        active_ch = 2'd2; in_service = 1'b1; mask_clr = 4'b0100; cyc(1); mask_clr = '0;
        cnt_expired[2] = 1'b1; cyc(1);
        status_rd = 1'b1; cyc(3); status_rd = 1'b0;
        cnt_expired = '0; in_service = 1'b0; cyc(2);
        chk("R10", "held re-trigger blocked", tc_status[2], 0);

        // R7 R8: clear/read on the same edge as an event, set wins
        active_ch = 2'd0; in_service = 1'b1;
        cyc(1);
        cnt_expired[0] = 1'b1; status_rd = 1'b1; mask_clr = 4'b0001;
        cyc(1);
        cnt_expired = '0; status_rd = 1'b0; mask_clr = '0;
        chk("R7", "mask0 set wins", mask[0], 1);
        chk("R8", "tc0 set wins", tc_status[0], 1);
        cyc(2); in_service = 1'b0; cyc(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule